// File: doc/BRIEF.md
# Single-Cycle 64-bit RISC-V Subset Core

This block is a one-instruction-per-clock 64-bit processor datapath. It executes seven operations: `add`, `addi`, `ld`, `sd`, `beq`, `jal` and `jalr`. Each instruction is fetched from a private instruction store at the current PC and decoded. It then reads two registers, forms its second operand, optionally touches a private data store, and commits its result on the next rising edge. The PC is updated on that same edge. There is no pipelining, so every instruction's effects are complete before the next one is fetched.

Both stores are filled from outside through a single valid/ready fill port. The fill port accepts words only while the core is held in reset. While the core runs, `fill_ready` stays low and any offered word is held off indefinitely, which is the port's back-pressure. A transfer completes on a rising edge where `fill_valid` and `fill_ready` are both high. Software-visible progress is observed through the PC output and a write-back view. The write-back view shows, in the same cycle, the register write that the instruction at `pc_o` will commit at the next edge.

Top module: `sc64_core`

## Requirements
- R1: A synchronous active-high `rst` sets the PC to 0 and clears every register. While `rst` is high, no register write is reported or performed.
- R2: `fill_ready` is high exactly while `rst` is high. On an edge with `fill_valid` and `fill_ready` both high, the word at index `fill_addr` is written. When `fill_dmem` = 1 it goes to the data store as the full 64-bit `fill_data`. When `fill_dmem` = 0 it goes to the instruction store as `fill_data[31:0]`. A fill offered while running changes neither store nor the execution.
- R3: `add` (opcode 0110011, funct3 000, funct7 0000000) writes rs1 + rs2 into rd. The register fields are rd = [11:7], rs1 = [19:15] and rs2 = [24:20].
- R4: `addi` (opcode 0010011, funct3 000) writes rs1 plus the 12-bit immediate in instruction bits [31:20], sign-extended to 64 bits, into rd.
- R5: Register x0 always reads as zero. An instruction naming rd = x0 writes nothing, and `rd_we_o` stays low for it.
- R6: `ld` (opcode 0000011, funct3 011) loads a 64-bit word into rd from address rs1 plus the I immediate. `sd` (opcode 0100011, funct3 011) stores rs2 at address rs1 plus the S immediate. The S immediate is {[31:25],[11:7]}, sign-extended. The data-store word index is address bits [3 +: log2 depth].
- R7: `beq` (opcode 1100011, funct3 000) moves the PC to its own address plus the sign-extended B offset, an even byte offset with bit 0 implied zero. This happens when rs1 equals rs2; otherwise the PC advances by 4. It writes no register.
- R8: `jal` (opcode 1101111) writes PC+4 into rd and moves the PC by its sign-extended J offset, which also has bit 0 implied zero.
- R9: `jalr` (opcode 1100111, funct3 000) writes PC+4 into rd and moves the PC to rs1 plus the unscaled I immediate, with bit 0 of the sum cleared.
- R10: Any other encoding executes as a no-op: it writes nothing and advances the PC by 4.
- R11: Every instruction other than a taken branch, `jal` or `jalr` advances the PC by 4. `rd_we_o`, `rd_idx_o` and `rd_data_o` describe the write of the instruction currently at `pc_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also opens the fill port |
| fill_valid | input | 1 | A fill word is offered |
| fill_ready | output | 1 | Fill port accepts words (only during reset) |
| fill_dmem | input | 1 | 1 selects the data store, 0 the instruction store |
| fill_addr | input | FAW (6) | Word index within the selected store |
| fill_data | input | 64 | Fill word; instruction store takes bits [31:0] |
| pc_o | output | 64 | Address of the instruction now executing |
| rd_we_o | output | 1 | The current instruction writes a register at the next edge |
| rd_idx_o | output | 5 | Destination register of that write |
| rd_data_o | output | 64 | Value of that write |

## Verification
`pc_o` and the write-back view are combinational for the instruction at the current PC, so an instruction's result is visible in the cycle it executes. Its PC successor appears one rising edge later. The bench queues one expected PC/write-back pair per executed instruction and pops one per falling edge. No expectation is therefore ever compared before its edge has passed. Stored values are confirmed through a later load, and branch targets through the PC sequence. The fill port's back-pressure is checked by offering a word while running and observing the unchanged loop at the ports.

// File: rtl/sc64_pkg.sv
package sc64_pkg;
  localparam int XLEN = 64;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_BRA   = 7'b1100011;
  localparam logic [6:0] OPC_JAL   = 7'b1101111;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;

  typedef enum logic [2:0] {
    CL_NOP, CL_ADD, CL_ADDI, CL_LD, CL_SD, CL_BEQ, CL_JAL, CL_JALR
  } cls_e;

  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;
  typedef enum logic [1:0] {NPC_SEQ, NPC_BRA, NPC_REL, NPC_REG} npc_sel_e;

  typedef struct packed {
    cls_e     cls;
    logic     opb_imm;
    logic     reg_we;
    logic     mem_we;
    wb_sel_e  wb_sel;
    npc_sel_e npc_sel;
  } ctl_t;
endpackage

// File: rtl/sc64_decode.sv
module sc64_decode
  import sc64_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '{cls: CL_NOP, opb_imm: 1'b0, reg_we: 1'b0, mem_we: 1'b0,
            wb_sel: WB_ALU, npc_sel: NPC_SEQ};
    case (opcode)
      OPC_REG:
        if (funct3 == 3'b000 && funct7 == 7'b0000000) begin
          ctl.cls    = CL_ADD;
          ctl.reg_we = 1'b1;
        end
      OPC_IMM:
        if (funct3 == 3'b000) begin
          ctl.cls     = CL_ADDI;
          ctl.opb_imm = 1'b1;
          ctl.reg_we  = 1'b1;
        end
      OPC_LOAD:
        if (funct3 == 3'b011) begin
          ctl.cls     = CL_LD;
          ctl.opb_imm = 1'b1;
          ctl.reg_we  = 1'b1;
          ctl.wb_sel  = WB_MEM;
        end
      OPC_STORE:
        if (funct3 == 3'b011) begin
          ctl.cls     = CL_SD;
          ctl.opb_imm = 1'b1;
          ctl.mem_we  = 1'b1;
        end
      OPC_BRA:
        if (funct3 == 3'b000) begin
          ctl.cls     = CL_BEQ;
          ctl.npc_sel = NPC_BRA;
        end
      OPC_JAL: begin
        ctl.cls     = CL_JAL;
        ctl.reg_we  = 1'b1;
        ctl.wb_sel  = WB_LINK;
        ctl.npc_sel = NPC_REL;
      end
      OPC_JALR:
        if (funct3 == 3'b000) begin
          ctl.cls     = CL_JALR;
          ctl.opb_imm = 1'b1;
          ctl.reg_we  = 1'b1;
          ctl.wb_sel  = WB_LINK;
          ctl.npc_sel = NPC_REG;
        end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc64_immgen.sv
module sc64_immgen
  import sc64_pkg::*;
(
  input  logic [31:7]     ins,
  input  cls_e            cls,
  output logic [XLEN-1:0] imm
);
  always_comb begin
    case (cls)
      CL_SD:   imm = {{(XLEN-12){ins[31]}}, ins[31:25], ins[11:7]};
      CL_BEQ:  imm = {{(XLEN-13){ins[31]}}, ins[31], ins[7], ins[30:25],
                      ins[11:8], 1'b0};
      CL_JAL:  imm = {{(XLEN-21){ins[31]}}, ins[31], ins[19:12], ins[20],
                      ins[30:21], 1'b0};
      default: imm = {{(XLEN-12){ins[31]}}, ins[31:20]};
    endcase
  end
endmodule

// File: rtl/sc64_alu.sv
module sc64_alu
  import sc64_pkg::*;
(
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [XLEN-1:0] cmp_b,
  output logic [XLEN-1:0] sum,
  output logic            same
);
  assign sum  = op_a + op_b;
  assign same = (op_a == cmp_b);
endmodule

// File: rtl/sc64_regfile.sv
module sc64_regfile
  import sc64_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [RAW-1:0]  ra1,
  input  logic [RAW-1:0]  ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            we,
  input  logic [RAW-1:0]  wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc64_core.sv
module sc64_core
  import sc64_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int FAW = (IAW > DAW) ? IAW : DAW
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            fill_valid,
  output logic            fill_ready,
  input  logic            fill_dmem,
  input  logic [FAW-1:0]  fill_addr,
  input  logic [XLEN-1:0] fill_data,
  output logic [XLEN-1:0] pc_o,
  output logic            rd_we_o,
  output logic [RAW-1:0]  rd_idx_o,
  output logic [XLEN-1:0] rd_data_o
);
  logic [XLEN-1:0] pc, pc_next, pc_plus4, pc_rel;
  logic [31:0]     inst;
  ctl_t            ctl;
  logic [XLEN-1:0] rs1_val, rs2_val, imm, opb, alu_sum, mem_rdata, wb_data;
  logic            alu_eq, wb_en, fill_fire;

  logic [31:0]     imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  assign fill_ready = rst;
  assign fill_fire  = fill_valid & fill_ready;

  assign inst = imem[pc[2 +: IAW]];

  sc64_decode u_dec (
    .opcode(inst[6:0]), .funct3(inst[14:12]), .funct7(inst[31:25]), .ctl(ctl)
  );

  sc64_immgen u_imm (.ins(inst[31:7]), .cls(ctl.cls), .imm(imm));

  assign wb_en = ctl.reg_we & ~rst;

  sc64_regfile u_rf (
    .clk(clk), .rst(rst),
    .ra1(inst[19:15]), .ra2(inst[24:20]),
    .rd1(rs1_val), .rd2(rs2_val),
    .we(wb_en), .wa(inst[11:7]), .wd(wb_data)
  );

  assign opb = ctl.opb_imm ? imm : rs2_val;

  sc64_alu u_alu (
    .op_a(rs1_val), .op_b(opb), .cmp_b(rs2_val), .sum(alu_sum), .same(alu_eq)
  );

  assign mem_rdata = dmem[alu_sum[3 +: DAW]];
  assign pc_plus4  = pc + XLEN'(4);
  assign pc_rel    = pc + imm;

  always_comb begin
    case (ctl.wb_sel)
      WB_MEM:  wb_data = mem_rdata;
      WB_LINK: wb_data = pc_plus4;
      default: wb_data = alu_sum;
    endcase
  end

  always_comb begin
    case (ctl.npc_sel)
      NPC_BRA: pc_next = alu_eq ? pc_rel : pc_plus4;
      NPC_REL: pc_next = pc_rel;
      NPC_REG: pc_next = {alu_sum[XLEN-1:1], 1'b0};
      default: pc_next = pc_plus4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  always_ff @(posedge clk) begin
    if (fill_fire && !fill_dmem) imem[fill_addr[IAW-1:0]] <= fill_data[31:0];
  end

  always_ff @(posedge clk) begin
    if (fill_fire && fill_dmem)   dmem[fill_addr[DAW-1:0]] <= fill_data;
    else if (!rst && ctl.mem_we)  dmem[alu_sum[3 +: DAW]]  <= rs2_val;
  end

  assign pc_o      = pc;
  assign rd_we_o   = wb_en && (inst[11:7] != '0);
  assign rd_idx_o  = inst[11:7];
  assign rd_data_o = wb_data;
endmodule

// File: rtl/sc64_checker.sv
module sc64_checker
  import sc64_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc_o,
  input logic            rd_we_o,
  input logic [RAW-1:0]  rd_idx_o,
  input logic [XLEN-1:0] rd_data_o,
  input cls_e            cls,
  input logic [XLEN-1:0] rs1_val,
  input logic [XLEN-1:0] rs2_val,
  input logic [XLEN-1:0] imm
);
  p_pc_zero_r1: assert property (@(posedge clk) rst |=> pc_o == '0);

  p_quiet_reset_r1: assert property (@(posedge clk) rst |-> !rd_we_o);

  p_no_x0_write_r5: assert property (@(posedge clk) disable iff (rst)
    rd_we_o |-> rd_idx_o != '0);

  p_seq_step_r11: assert property (@(posedge clk) disable iff (rst)
    (cls inside {CL_NOP, CL_ADD, CL_ADDI, CL_LD, CL_SD})
    |=> pc_o == $past(pc_o) + XLEN'(4));

  p_beq_fall_r7: assert property (@(posedge clk) disable iff (rst)
    (cls == CL_BEQ && rs1_val != rs2_val) |=> pc_o == $past(pc_o) + XLEN'(4));

  p_beq_take_r7: assert property (@(posedge clk) disable iff (rst)
    (cls == CL_BEQ && rs1_val == rs2_val) |=> pc_o == $past(pc_o) + $past(imm));

  p_jal_link_r8: assert property (@(posedge clk) disable iff (rst)
    (cls == CL_JAL && rd_we_o) |-> rd_data_o == pc_o + XLEN'(4));

  p_jalr_even_r9: assert property (@(posedge clk) disable iff (rst)
    (cls == CL_JALR) |=> pc_o == ($past(rs1_val + imm) & ~XLEN'(1)));
endmodule

bind sc64_core sc64_checker u_chk (
  .clk(clk), .rst(rst), .pc_o(pc_o), .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o),
  .rd_data_o(rd_data_o), .cls(ctl.cls), .rs1_val(rs1_val), .rs2_val(rs2_val),
  .imm(imm)
);

// File: tb/test_sc64_core.sv
`timescale 1ns/1ps
module test_sc64_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic        fill_dmem = 1'b0;
  logic [5:0]  fill_addr = '0;
  logic [63:0] fill_data = '0;
  logic [63:0] pc_o;
  logic        rd_we_o;
  logic [4:0]  rd_idx_o;
  logic [63:0] rd_data_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [63:0] q_pc[$];
  logic        q_we[$];
  logic [4:0]  q_idx[$];
  logic [63:0] q_dat[$];
  string       q_req[$];

  localparam logic [63:0] DWORD = 64'h1122_3344_5566_7788;

  always #2.5 clk = ~clk;

  sc64_core i_sc64_core (
    .clk(clk), .rst(rst), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_dmem(fill_dmem), .fill_addr(fill_addr), .fill_data(fill_data),
    .pc_o(pc_o), .rd_we_o(rd_we_o), .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o)
  );

  function automatic logic [31:0] enc_i(logic [11:0] im, logic [4:0] s1,
                                        logic [2:0] f3, logic [4:0] d, logic [6:0] op);
    return {im, s1, f3, d, op};
  endfunction
  function automatic logic [31:0] enc_r(logic [4:0] s2, logic [4:0] s1, logic [4:0] d);
    return {7'b0, s2, s1, 3'b000, d, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_s(logic [11:0] im, logic [4:0] s2, logic [4:0] s1);
    return {im[11:5], s2, s1, 3'b011, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(logic [12:0] im, logic [4:0] s2, logic [4:0] s1);
    return {im[12], im[10:5], s2, s1, 3'b000, im[4:1], im[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_j(logic [20:0] im, logic [4:0] d);
    return {im[20], im[10:1], im[11], im[19:12], d, 7'b1101111};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fill(bit dm, int a, logic [63:0] d);
    fill_valid = 1'b1; fill_dmem = dm; fill_addr = 6'(a); fill_data = d;
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic expect_step(logic [63:0] p, bit we, logic [4:0] idx,
                             logic [63:0] d, string req);
    q_pc.push_back(p); q_we.push_back(we); q_idx.push_back(idx);
    q_dat.push_back(d); q_req.push_back(req);
  endtask

  // Monitor: one executed instruction per falling edge while running.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && q_pc.size() > 0) begin
        logic [63:0] ep, ed; logic ew; logic [4:0] ei; string rq;
        ep = q_pc.pop_front(); ew = q_we.pop_front(); ei = q_idx.pop_front();
        ed = q_dat.pop_front(); rq = q_req.pop_front();
        check(pc_o == ep, rq, "pc", pc_o, ep);
        check(rd_we_o == ew, rq, "write enable", 64'(rd_we_o), 64'(ew));
        if (ew && rd_we_o) begin
          check(rd_idx_o == ei, rq, "dest reg", 64'(rd_idx_o), 64'(ei));
          check(rd_data_o == ed, rq, "write data", rd_data_o, ed);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(pc_o == 64'h0, "R1", "reset pc", pc_o, 64'h0);
    check(!rd_we_o, "R1", "reset write enable", 64'(rd_we_o), 64'h0);
    check(fill_ready, "R2", "ready in reset", 64'(fill_ready), 64'h1);
    @(posedge clk); #1;

    fill(1'b1, 2, DWORD);
    fill(1'b0, 0,  enc_i(12'd5,   5'd0, 3'b000, 5'd1, 7'b0010011));
    fill(1'b0, 1,  enc_i(12'hFFD, 5'd0, 3'b000, 5'd2, 7'b0010011));
    fill(1'b0, 2,  enc_r(5'd2, 5'd1, 5'd3));
    fill(1'b0, 3,  enc_i(12'd7,   5'd1, 3'b000, 5'd0, 7'b0010011));
    fill(1'b0, 4,  enc_r(5'd1, 5'd0, 5'd4));
    fill(1'b0, 5,  enc_i(12'd16,  5'd0, 3'b011, 5'd5, 7'b0000011));
    fill(1'b0, 6,  enc_s(12'd38,  5'd5, 5'd3));
    fill(1'b0, 7,  enc_i(12'd40,  5'd0, 3'b011, 5'd6, 7'b0000011));
    fill(1'b0, 8,  enc_b(13'd8,   5'd6, 5'd5));
    fill(1'b0, 9,  enc_i(12'd1,   5'd0, 3'b000, 5'd7, 7'b0010011));
    fill(1'b0, 10, enc_b(13'd8,   5'd2, 5'd1));
    fill(1'b0, 11, enc_j(21'd12,  5'd8));
    fill(1'b0, 12, enc_i(12'd2,   5'd0, 3'b000, 5'd7, 7'b0010011));
    fill(1'b0, 13, enc_i(12'd2,   5'd0, 3'b000, 5'd7, 7'b0010011));
    fill(1'b0, 14, 64'h0000_007F);
    fill(1'b0, 15, enc_i(12'h04F, 5'd0, 3'b000, 5'd9, 7'b0010011));
    fill(1'b0, 16, enc_i(12'd2,   5'd9, 3'b000, 5'd10, 7'b1100111));
    fill(1'b0, 17, enc_i(12'd3,   5'd0, 3'b000, 5'd7, 7'b0010011));
    fill(1'b0, 18, enc_i(12'd3,   5'd0, 3'b000, 5'd7, 7'b0010011));
    fill(1'b0, 19, enc_j(21'd12,  5'd0));
    fill(1'b0, 20, enc_b(13'h1FFC, 5'd0, 5'd0));
    fill(1'b0, 21, enc_i(12'd4,   5'd0, 3'b000, 5'd7, 7'b0010011));
    fill(1'b0, 22, enc_r(5'd1, 5'd3, 5'd11));
    fill(1'b0, 23, enc_j(21'd0,   5'd0));

    expect_step(64'h00, 1, 5'd1,  64'd5, "R4");
    expect_step(64'h04, 1, 5'd2,  64'hFFFF_FFFF_FFFF_FFFD, "R4");
    expect_step(64'h08, 1, 5'd3,  64'd2, "R3");
    expect_step(64'h0C, 0, 5'd0,  64'd0, "R5");
    expect_step(64'h10, 1, 5'd4,  64'd5, "R5");
    expect_step(64'h14, 1, 5'd5,  DWORD, "R6");
    expect_step(64'h18, 0, 5'd0,  64'd0, "R6");
    expect_step(64'h1C, 1, 5'd6,  DWORD, "R6");
    expect_step(64'h20, 0, 5'd0,  64'd0, "R7");
    expect_step(64'h28, 0, 5'd0,  64'd0, "R7");
    expect_step(64'h2C, 1, 5'd8,  64'h30, "R8");
    expect_step(64'h38, 0, 5'd0,  64'd0, "R8");
    expect_step(64'h3C, 1, 5'd9,  64'h4F, "R10");
    expect_step(64'h40, 1, 5'd10, 64'h44, "R9");
    expect_step(64'h50, 0, 5'd0,  64'd0, "R9");
    expect_step(64'h4C, 0, 5'd0,  64'd0, "R7");
    expect_step(64'h58, 1, 5'd11, 64'd7, "R11");
    expect_step(64'h5C, 0, 5'd0,  64'd0, "R8");
    expect_step(64'h5C, 0, 5'd0,  64'd0, "R11");

    rst = 1'b0;
    while (q_pc.size() != 0) @(negedge clk);

    // Fill offered while running must be held off and change nothing.
    @(posedge clk); #1;
    fill_valid = 1'b1; fill_dmem = 1'b0; fill_addr = 6'd23;
    fill_data  = 64'(enc_i(12'd1, 5'd0, 3'b000, 5'd12, 7'b0010011));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (k == 3) fill_valid = 1'b0;
      check(!fill_ready, "R2", "ready while running", 64'(fill_ready), 64'h0);
      check(pc_o == 64'h5C && !rd_we_o, "R2", "loop unchanged", pc_o, 64'h5C);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule